// File: doc/BRIEF.md
# Pipelined Burst Memory

This block is a behavioural synchronous memory that serves short bursts of four words. On every rising clock edge it captures the address, the chip enables, the two address strobes, the advance input, the write controls and the write data. That captured cycle then goes to a word array. For a read, the array output is loaded into an output register, and that register drives the data bus. Read data and deselects therefore both reach the bus one clock after the cycle is captured. Three chip enables support depth expansion. An asynchronous output enable and a sleep input gate the bus drive.

The strobes follow two different rules. The processor strobe (`ads_proc_n`) only counts while `ce_n` is low, and it always opens a read. A write to that burst is made on a later wait cycle. The controller strobe (`ads_ctrl_n`) opens a read or a write, chosen by the write controls, or it deselects the part. When both strobes are high, the burst either advances or holds its address, depending on `adv_n`. The burst low bits count either linearly or in XOR order.

The control is a three-state machine whose state is the kind of the captured cycle: `CYC_DESEL`, `CYC_READ` or `CYC_WRITE`. Its transitions are:
- start-read: any state to `CYC_READ`.
- start-write: any state to `CYC_WRITE`.
- deselect: a strobe with an inactive enable, to `CYC_DESEL`.
- continue/suspend: `CYC_READ` or `CYC_WRITE` to either of those two, chosen by the write controls.
- idle-hold: `CYC_DESEL` to itself when no strobe is present.
- sleep: any state to `CYC_DESEL`.

Top module: `pipe_burst_ram`

## Requirements
- R1: A read cycle captured at edge n puts the addressed word on `data_out`, with `bus_drive` high, after edge n+1, provided `oe_n` is low. After edge n itself the bus still reflects the cycle before.
- R2: Byte lane k covers data bits 8k to 8k+7. Its active-low enable `lane_n[k]` writes that lane only while `bwe_n` is low. With `bwe_n` high, the cycle is a read and the word is not changed.
- R3: With `gw_n` low, all four lanes are written, whatever the values of `bwe_n` and `lane_n`.
- R4: A low `ads_proc_n` with the chip selected starts a read, even when the write controls are active. A wait cycle that follows (both strobes high, `adv_n` high, write controls active) writes the same address.
- R5: A low `ads_ctrl_n` with the chip selected captures a new address. It starts a write when the write controls are active and a read otherwise.
- R6: A strobe with `ce_n` high, `ce2` low or `ce2_n` high deselects the part. `bus_drive` goes low one edge later. While deselected, cycles with both strobes high do nothing.
- R7: While `ce_n` is high, `ads_proc_n` is ignored. With `ads_ctrl_n` also high, the burst continues as if no strobe were present.
- R8: With both strobes high, `adv_n` low moves the burst to its next address and `adv_n` high holds the current address.
- R9: The burst order depends on `seq_linear`. The i-th word of a burst starting at low bits s is at low bits (s+i) mod 4 when `seq_linear` is 1, and at s XOR i when it is 0. The upper bits stay fixed.
- R10: `oe_n` high forces `bus_drive` low at once, with no clock. One edge after a write cycle is captured, `bus_drive` is low, even with `oe_n` low.
- R11: `sleep` high forces `bus_drive` low at once. While it is high, strobes are ignored and no write takes place.
- R12: During and after reset, `bus_drive` is low and the part is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, captured with a strobe |
| data_in | input | DATA_W | Write data, captured every edge |
| data_out | output | DATA_W | Output register contents |
| bus_drive | output | 1 | High when the bus is driven with `data_out` |
| ce_n | input | 1 | Primary enable, active low; gates `ads_proc_n` |
| ce2 | input | 1 | Secondary enable, active high |
| ce2_n | input | 1 | Secondary enable, active low |
| ads_proc_n | input | 1 | Processor address strobe, read-only start |
| ads_ctrl_n | input | 1 | Controller address strobe |
| adv_n | input | 1 | Burst advance, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_n | input | DATA_W/8 | Per-lane write enables, active low |
| gw_n | input | 1 | Global write, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| seq_linear | input | 1 | 1 selects linear burst order, 0 selects XOR order |
| sleep | input | 1 | Standby request, active high |

## Verification
The bench uses the default parameters: 256 words of 32 bits with a 2-bit burst counter. This size keeps every burst wrap within a single four-word group. It also lets the bench keep a reference copy of the whole array. Bursts start at low bits 1 and 3, because for those start points the linear and XOR orders give different sequences; a start at 0 or 2 would not tell the two orders apart. The four 8-bit lanes allow masks in which enabled and disabled lanes alternate.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        CYC_DESEL = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] start_lo,
    input  logic [BURST_W-1:0] beat,
    input  logic               linear,
    output logic [BURST_W-1:0] offs
);
    logic [BURST_W-1:0] lin_offs;
    logic [BURST_W-1:0] xor_offs;

    assign lin_offs = start_lo + beat;
    assign xor_offs = start_lo ^ beat;
    assign offs     = linear ? lin_offs : xor_offs;
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int BURST_W = 2,
    parameter int LANES   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_mask,
    input  logic              ce_n,
    input  logic              ce2,
    input  logic              ce2_n,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    input  logic              linear,
    input  logic              sleep,
    output cyc_e              state,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [LANES-1:0]  cyc_mask,
    output logic [DATA_W-1:0] cyc_data
);
    localparam int HI_W = ADDR_W - BURST_W;

    cyc_e               state_q, state_n;
    logic [HI_W-1:0]    hi_q, hi_n;
    logic [BURST_W-1:0] base_q, base_n;
    logic [BURST_W-1:0] cnt_q, cnt_n;
    logic [BURST_W-1:0] offs_n;
    logic [ADDR_W-1:0]  addr_q;
    logic [LANES-1:0]   mask_q;
    logic [DATA_W-1:0]  data_q;

    logic selected, proc_go, ctrl_go, start, wr_req;

    assign selected = !ce_n && ce2 && !ce2_n;
    assign proc_go  = !ads_proc_n && !ce_n;
    assign ctrl_go  = !ads_ctrl_n && !proc_go;
    assign start    = proc_go || ctrl_go;
    assign wr_req   = |lane_mask;

    always_comb begin
        state_n = state_q;
        hi_n    = hi_q;
        base_n  = base_q;
        cnt_n   = cnt_q;
        if (sleep) begin
            state_n = CYC_DESEL;
        end else if (start) begin
            hi_n   = addr[ADDR_W-1:BURST_W];
            base_n = addr[BURST_W-1:0];
            cnt_n  = '0;
            if (!selected)    state_n = CYC_DESEL;
            else if (proc_go) state_n = CYC_READ;
            else              state_n = wr_req ? CYC_WRITE : CYC_READ;
        end else begin
            unique case (state_q)
                CYC_DESEL: state_n = CYC_DESEL;
                CYC_READ, CYC_WRITE: begin
                    if (!adv_n) cnt_n = cnt_q + 1'b1;
                    state_n = wr_req ? CYC_WRITE : CYC_READ;
                end
                default: state_n = CYC_DESEL;
            endcase
        end
    end

    burst_seq #(.BURST_W(BURST_W)) u_seq (
        .start_lo (base_n),
        .beat     (cnt_n),
        .linear   (linear),
        .offs     (offs_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_DESEL;
            hi_q    <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            addr_q  <= '0;
            mask_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            hi_q    <= hi_n;
            base_q  <= base_n;
            cnt_q   <= cnt_n;
            addr_q  <= {hi_n, offs_n};
            mask_q  <= (state_n == CYC_WRITE) ? lane_mask : '0;
            data_q  <= wdata;
        end
    end

    always_comb begin
        state    = state_q;
        cyc_addr = addr_q;
        cyc_mask = mask_q;
        cyc_data = data_q;
    end

    AST_PROC_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !ads_proc_n && !ce_n && ce2 && !ce2_n) |=> (state_q == CYC_READ)); // R4

    AST_STROBE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && ((!ads_proc_n && !ce_n) || !ads_ctrl_n) && (ce_n || !ce2 || ce2_n))
        |=> (state_q == CYC_DESEL)); // R6

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && ads_proc_n && ads_ctrl_n && adv_n && state_q != CYC_DESEL)
        |=> $stable(addr_q)); // R8

    AST_SLEEP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state_q == CYC_DESEL && mask_q == '0)); // R11
endmodule

// File: rtl/burst_array.sv
module burst_array
    import burst_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  mask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              drive
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;
    logic              drive_q;

    always_ff @(posedge clk) begin
        if (kind == CYC_WRITE) begin
            for (int k = 0; k < LANES; k++) begin
                if (mask[k]) mem[addr][8*k +: 8] <= wdata[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            drive_q <= 1'b0;
        end else begin
            drive_q <= (kind == CYC_READ);
            if (kind == CYC_READ) rdata_q <= mem[addr];
        end
    end

    assign rdata = rdata_q;
    assign drive = drive_q;

    AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CYC_WRITE) |=> !drive_q); // R10
endmodule

// File: rtl/pipe_burst_ram.sv
module pipe_burst_ram
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int BURST_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data_in,
    output logic [DATA_W-1:0]   data_out,
    output logic                bus_drive,
    input  logic                ce_n,
    input  logic                ce2,
    input  logic                ce2_n,
    input  logic                ads_proc_n,
    input  logic                ads_ctrl_n,
    input  logic                adv_n,
    input  logic                bwe_n,
    input  logic [DATA_W/8-1:0] lane_n,
    input  logic                gw_n,
    input  logic                oe_n,
    input  logic                seq_linear,
    input  logic                sleep
);
    localparam int LANES = DATA_W / 8;

    cyc_e              state;
    logic [ADDR_W-1:0] cyc_addr;
    logic [LANES-1:0]  cyc_mask;
    logic [DATA_W-1:0] cyc_data;
    logic [LANES-1:0]  lane_mask;
    logic              drive_q;

    always_comb begin
        if (!gw_n)       lane_mask = '1;
        else if (!bwe_n) lane_mask = ~lane_n;
        else             lane_mask = '0;
    end

    burst_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W), .LANES(LANES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wdata      (data_in),
        .lane_mask  (lane_mask),
        .ce_n       (ce_n),
        .ce2        (ce2),
        .ce2_n      (ce2_n),
        .ads_proc_n (ads_proc_n),
        .ads_ctrl_n (ads_ctrl_n),
        .adv_n      (adv_n),
        .linear     (seq_linear),
        .sleep      (sleep),
        .state      (state),
        .cyc_addr   (cyc_addr),
        .cyc_mask   (cyc_mask),
        .cyc_data   (cyc_data)
    );

    burst_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (state),
        .addr  (cyc_addr),
        .mask  (cyc_mask),
        .wdata (cyc_data),
        .rdata (data_out),
        .drive (drive_q)
    );

    assign bus_drive = drive_q && !oe_n && !sleep;

    AST_DESEL_QUIETS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_DESEL) |=> !bus_drive); // R6
endmodule

// File: tb/pipe_burst_ram_test.sv
module pipe_burst_ram_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] data_in = '0;
    logic [31:0] data_out;
    logic        bus_drive;
    logic        ce_n, ce2, ce2_n, ads_proc_n, ads_ctrl_n, adv_n, bwe_n, gw_n, oe_n;
    logic        seq_linear, sleep;
    logic [3:0]  lane_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] model [256];

    always #2 clk = ~clk;

    pipe_burst_ram uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .data_out(data_out), .bus_drive(bus_drive), .ce_n(ce_n), .ce2(ce2),
        .ce2_n(ce2_n), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
        .adv_n(adv_n), .bwe_n(bwe_n), .lane_n(lane_n), .gw_n(gw_n),
        .oe_n(oe_n), .seq_linear(seq_linear), .sleep(sleep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_idle();
        ads_proc_n = 1; ads_ctrl_n = 1; adv_n = 1;
        gw_n = 1; bwe_n = 1; lane_n = 4'hF;
        ce_n = 0; ce2 = 1; ce2_n = 0; oe_n = 0; sleep = 0;
    endtask

    task automatic desel();
        set_idle();
        ads_ctrl_n = 0; ce_n = 1;
        tick();
        set_idle();
    endtask

    function automatic logic [3:0] mask_of(input logic g, input logic b, input logic [3:0] l);
        if (!g) return 4'hF;
        if (!b) return ~l;
        return 4'h0;
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] m);
        for (int k = 0; k < 4; k++)
            if (m[k]) model[a][8*k +: 8] = d[8*k +: 8];
    endfunction

    function automatic logic [7:0] seq_at(input logic [7:0] b, input int i, input logic lin);
        logic [1:0] ii = i[1:0];
        return {b[7:2], lin ? b[1:0] + ii : b[1:0] ^ ii};
    endfunction

    task automatic wr_op(input logic [7:0] a, input logic [31:0] d,
                         input logic g, input logic b, input logic [3:0] l);
        desel();
        ads_ctrl_n = 0; addr = a; data_in = d; gw_n = g; bwe_n = b; lane_n = l;
        tick();
        model_wr(a, d, mask_of(g, b, l));
        desel();
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        desel();
        ads_ctrl_n = 0; addr = a;
        tick();
        chk({tag, " R1 not yet driven"}, {31'd0, bus_drive}, 32'd0);
        set_idle();
        tick();
        chk({tag, " drive"}, {31'd0, bus_drive}, 32'd1);
        chk({tag, " data"}, data_out, model[a]);
    endtask

    task automatic t_reset();
        set_idle(); seq_linear = 1;
        rst_n = 0;
        tick(); tick();
        chk("R12 drive in reset", {31'd0, bus_drive}, 32'd0);
        rst_n = 1;
        tick();
        chk("R12 drive after reset", {31'd0, bus_drive}, 32'd0);
    endtask

    task automatic t_global();
        wr_op(8'h10, 32'hA5A5_0F0F, 0, 1, 4'hF);
        rd_chk(8'h10, "R3 gw bwe high");
        wr_op(8'h11, 32'h1234_5678, 0, 0, 4'hF);
        rd_chk(8'h11, "R3 gw lanes off");
        wr_op(8'h12, 32'hCAFE_0001, 1, 0, 4'h0);
        rd_chk(8'h12, "R5 ctrl write all lanes");
    endtask

    task automatic t_lanes();
        wr_op(8'h20, 32'hFFFF_FFFF, 0, 1, 4'hF);
        wr_op(8'h20, 32'h1122_3344, 1, 0, 4'b1010);
        chk("R2 model lanes 0,2", model[8'h20], 32'hFF22_FF44);
        rd_chk(8'h20, "R2 lanes 0,2");
        wr_op(8'h20, 32'h0000_0000, 1, 1, 4'h0);
        rd_chk(8'h20, "R2 bwe high no write");
        wr_op(8'h21, 32'h0, 0, 1, 4'hF);
        wr_op(8'h21, 32'hDEAD_BEEF, 1, 0, 4'b0111);
        rd_chk(8'h21, "R2 lane 3 only");
    endtask

    task automatic t_proc();
        wr_op(8'h30, 32'h0BAD_F00D, 0, 1, 4'hF);
        desel();
        ads_proc_n = 0; addr = 8'h30; gw_n = 0; data_in = 32'h7777_8888;
        tick();
        ads_proc_n = 1; adv_n = 1; gw_n = 0; data_in = 32'h7777_8888;
        tick();
        chk("R4 proc strobe read drive", {31'd0, bus_drive}, 32'd1);
        chk("R4 proc strobe read data", data_out, 32'h0BAD_F00D);
        set_idle();
        tick();
        chk("R10 released after write", {31'd0, bus_drive}, 32'd0);
        model[8'h30] = 32'h7777_8888;
        rd_chk(8'h30, "R4 wait-cycle write");
    endtask

    task automatic t_deselect();
        for (int e = 0; e < 3; e++) begin
            wr_op(8'h40, 32'h4040_0000 + e, 0, 1, 4'hF);
            desel();
            ads_ctrl_n = 0; addr = 8'h40;
            tick();
            ads_ctrl_n = 0;
            if (e == 0) ce_n = 1;
            if (e == 1) ce2 = 0;
            if (e == 2) ce2_n = 1;
            tick();
            chk("R6 read still out", data_out, model[8'h40]);
            chk("R6 drive before deselect", {31'd0, bus_drive}, 32'd1);
            set_idle(); adv_n = 0;
            tick();
            chk("R6 deselect one cycle", {31'd0, bus_drive}, 32'd0);
            tick();
            chk("R6 idle stays deselected", {31'd0, bus_drive}, 32'd0);
        end
    endtask

    task automatic t_proc_ignored();
        wr_op(8'h50, 32'h5050_5050, 0, 1, 4'hF);
        wr_op(8'h51, 32'h5151_5151, 0, 1, 4'hF);
        seq_linear = 1;
        desel();
        ads_ctrl_n = 0; addr = 8'h50;
        tick();
        set_idle(); ads_proc_n = 0; ce_n = 1; adv_n = 0; addr = 8'h99;
        tick();
        chk("R7 first word", data_out, 32'h5050_5050);
        set_idle();
        tick();
        chk("R7 burst continued", data_out, 32'h5151_5151);
        chk("R7 not deselected", {31'd0, bus_drive}, 32'd1);
    endtask

    task automatic rd_burst(input logic [7:0] b, input logic lin, input string tag);
        desel();
        seq_linear = lin;
        ads_ctrl_n = 0; addr = b;
        tick();
        set_idle(); adv_n = 0;
        tick();
        chk({tag, " R9 beat0"}, data_out, model[seq_at(b, 0, lin)]);
        tick();
        chk({tag, " R9 beat1"}, data_out, model[seq_at(b, 1, lin)]);
        tick();
        chk({tag, " R9 beat2"}, data_out, model[seq_at(b, 2, lin)]);
        adv_n = 1;
        tick();
        chk({tag, " R9 beat3"}, data_out, model[seq_at(b, 3, lin)]);
        tick();
        chk({tag, " R8 suspend holds"}, data_out, model[seq_at(b, 3, lin)]);
    endtask

    task automatic t_bursts();
        desel();
        seq_linear = 1;
        ads_ctrl_n = 0; addr = 8'h61; gw_n = 0; data_in = 32'h6000_0000;
        tick();
        model[seq_at(8'h61, 0, 1)] = 32'h6000_0000;
        for (int i = 1; i < 4; i++) begin
            ads_ctrl_n = 1; adv_n = 0; gw_n = 0; data_in = 32'h6000_0000 + i;
            tick();
            model[seq_at(8'h61, i, 1)] = 32'h6000_0000 + i;
        end
        rd_chk(8'h60, "R8 burst write wrap");
        rd_burst(8'h61, 1, "linear from 1");
        rd_burst(8'h63, 1, "linear from 3");
        rd_burst(8'h61, 0, "xor from 1");
        rd_burst(8'h63, 0, "xor from 3");
    endtask

    task automatic t_oe();
        wr_op(8'h70, 32'h7070_7070, 0, 1, 4'hF);
        desel();
        ads_ctrl_n = 0; addr = 8'h70;
        tick();
        set_idle();
        tick();
        chk("R10 driven with oe low", {31'd0, bus_drive}, 32'd1);
        oe_n = 1; #1;
        chk("R10 oe high async", {31'd0, bus_drive}, 32'd0);
        oe_n = 0; #1;
        chk("R10 oe low again", {31'd0, bus_drive}, 32'd1);
        sleep = 1; #1;
        chk("R11 sleep async", {31'd0, bus_drive}, 32'd0);
        sleep = 0;
        ads_ctrl_n = 0; addr = 8'h71; gw_n = 0; data_in = 32'h7171_7171;
        tick();
        set_idle();
        tick();
        chk("R10 write after read releases", {31'd0, bus_drive}, 32'd0);
        model[8'h71] = 32'h7171_7171;
        rd_chk(8'h71, "R10 write landed");
    endtask

    task automatic t_sleep();
        wr_op(8'h80, 32'h8080_8080, 0, 1, 4'hF);
        desel();
        sleep = 1;
        ads_ctrl_n = 0; addr = 8'h80; gw_n = 0; data_in = 32'h0;
        tick();
        set_idle(); sleep = 1;
        tick();
        chk("R11 no drive in sleep", {31'd0, bus_drive}, 32'd0);
        sleep = 0;
        rd_chk(8'h80, "R11 write ignored");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        @(negedge clk);
        t_reset();
        t_global();
        t_lanes();
        t_proc();
        t_deselect();
        t_proc_ignored();
        t_bursts();
        t_oe();
        t_sleep();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule